// File: doc/BRIEF.md
# DRAM Bank Timing Tracker

This block keeps the per-bank timing state that a DRAM command scheduler consults before issuing a command. Every cycle it samples one issued command: a kind (activate, read, write or precharge), a bank index and a row address. From that it keeps a set of down-counters for each bank and a pair of shared data-bus turnaround counters. Per bank it reports whether each of the four command kinds may legally go out in the current cycle, together with the bank's open/closed state and the row it holds.

A counter is loaded with its window length minus one when the command that starts the window is accepted. It then counts down once per clock, and the matching ready flag rises when the counter reaches zero. A read or write whose bank is closed, or whose row differs from the row held open, is refused. Such a command changes no state and raises a one-cycle error pulse. Each bank also counts the column accesses made to its open row, and asks for the row to be closed once a set number has been reached. The tracker only records commands; choosing which command to issue is left to the scheduler.

In the text below, "cycle 0" is the cycle in which a command is presented. A window of N cycles means the flag is first high in cycle N. An activate to an already open bank and a precharge to a closed bank are accepted by nobody and change nothing.

Top module: `dram_bank_tracker`

## Requirements
- R1: After synchronous reset, every bank is closed, `act_ok` is all ones, `rd_ok`, `wr_ok`, `pre_ok` and `close_req` are all zeros, and `col_err` is low.
- R2: An activate (cmd_kind 0) to a closed bank opens it and stores the row in that bank's slice `open_row[b*ROW_W +: ROW_W]`. The bank's `rd_ok`/`wr_ok` first rise T_RCD cycles after the activate, subject to R6.
- R3: `pre_ok` for a bank first rises T_RAS cycles after that bank's activate.
- R4: After an accepted write (cmd_kind 2), `pre_ok` for that bank stays low until T_WL + T_BURST + T_WR cycles after the write. This is the write data burst end plus the recovery time.
- R5: A precharge (cmd_kind 3) to an open bank closes it at once. Its `act_ok` first rises T_RP cycles after the precharge.
- R6: After an accepted write, `rd_ok` is low on every bank until T_WL + T_BURST + T_WTR cycles later. After an accepted read (cmd_kind 1), `wr_ok` is low on every bank until T_RTW cycles later.
- R7: A read or write to a closed bank, or with a row differing from the open row, raises `col_err` for exactly the next cycle. It leaves all bank and turnaround state unchanged.
- R8: `close_req` for a bank rises after MAX_ACC accepted column accesses to its open row. It stays high while the row is open and clears when the bank is precharged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_kind | input | 2 | 0 activate, 1 read, 2 write, 3 precharge |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_W | Row address of the command |
| act_ok | output | NB | Activate legal, one bit per bank |
| rd_ok | output | NB | Read legal, one bit per bank |
| wr_ok | output | NB | Write legal, one bit per bank |
| pre_ok | output | NB | Precharge legal, one bit per bank |
| bank_open | output | NB | Bank holds an open row |
| open_row | output | NB*ROW_W | Open row of each bank, bank b at bits b*ROW_W upward |
| close_req | output | NB | Access cap reached on the open row |
| col_err | output | 1 | Previous column command was refused |

## Verification
The bench measures the exact cycle in which each ready flag rises after its triggering command. A tracker loaded with the wrong window, or with the window itself rather than the window minus one, shows up as a flag that rises one cycle early or late. The write-to-precharge and write-to-read checks catch a design that forgets the write latency and burst length in the recovery start point. A design that times recovery from the write command only would release precharge or reads too soon. A refused read to a mismatched row is followed at once by a look at `wr_ok`; a design that lets refused commands load the turnaround counter would hold writes off there. The access cap is probed one access before and at the limit, which catches an off-by-one in the saturating counter.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_PRE = 2'd3
  } cmd_kind_e;
endpackage

// File: rtl/dbt_bank.sv
module dbt_bank #(
  parameter int ROW_W   = 8,
  parameter int CNT_W   = 8,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 7,
  parameter int T_RP    = 3,
  parameter int T_WREC  = 7,
  parameter int MAX_ACC = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_fire,
  input  logic             col_fire,
  input  logic             wr_fire,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] row_in,
  output logic             is_open,
  output logic [ROW_W-1:0] row_q,
  output logic             col_ready,
  output logic             pre_ready,
  output logic             act_ready,
  output logic             at_cap
);
  localparam int ACC_W = $clog2(MAX_ACC + 1);

  logic [CNT_W-1:0] rcd_q, ras_q, rp_q, wrec_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
      row_q   <= '0;
      rcd_q   <= '0;
      ras_q   <= '0;
      rp_q    <= '0;
      wrec_q  <= '0;
      acc_q   <= '0;
    end else begin
      rcd_q  <= (rcd_q  != '0) ? rcd_q  - 1'b1 : rcd_q;
      ras_q  <= (ras_q  != '0) ? ras_q  - 1'b1 : ras_q;
      rp_q   <= (rp_q   != '0) ? rp_q   - 1'b1 : rp_q;
      wrec_q <= (wrec_q != '0) ? wrec_q - 1'b1 : wrec_q;
      if (act_fire) begin
        is_open <= 1'b1;
        row_q   <= row_in;
        rcd_q   <= CNT_W'(T_RCD - 1);
        ras_q   <= CNT_W'(T_RAS - 1);
        acc_q   <= '0;
      end
      if (col_fire && acc_q != ACC_W'(MAX_ACC))
        acc_q <= acc_q + 1'b1;
      if (wr_fire)
        wrec_q <= CNT_W'(T_WREC - 1);
      if (pre_fire) begin
        is_open <= 1'b0;
        rp_q    <= CNT_W'(T_RP - 1);
        acc_q   <= '0;
      end
    end
  end

  assign col_ready = is_open && rcd_q == '0;
  assign pre_ready = is_open && ras_q == '0 && wrec_q == '0;
  assign act_ready = !is_open && rp_q == '0;
  assign at_cap    = is_open && acc_q == ACC_W'(MAX_ACC);
endmodule

// File: rtl/dbt_turn.sv
module dbt_turn #(
  parameter int CNT_W  = 8,
  parameter int T_W2R  = 6,
  parameter int T_RTW  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_fire,
  input  logic wr_fire,
  output logic rd_bus_ok,
  output logic wr_bus_ok
);
  logic [CNT_W-1:0] w2r_q, r2w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w2r_q <= '0;
      r2w_q <= '0;
    end else begin
      w2r_q <= wr_fire ? CNT_W'(T_W2R - 1) : (w2r_q != '0) ? w2r_q - 1'b1 : w2r_q;
      r2w_q <= rd_fire ? CNT_W'(T_RTW - 1) : (r2w_q != '0) ? r2w_q - 1'b1 : r2w_q;
    end
  end

  assign rd_bus_ok = w2r_q == '0;
  assign wr_bus_ok = r2w_q == '0;
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker #(
  parameter int NB      = 4,
  parameter int ROW_W   = 8,
  parameter int CNT_W   = 8,
  parameter int T_RCD   = 3,
  parameter int T_RAS   = 7,
  parameter int T_RP    = 3,
  parameter int T_WR    = 3,
  parameter int T_WL    = 2,
  parameter int T_BURST = 2,
  parameter int T_WTR   = 2,
  parameter int T_RTW   = 2,
  parameter int MAX_ACC = 16,
  parameter int BANK_W  = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_kind,
  input  logic [BANK_W-1:0]   cmd_bank,
  input  logic [ROW_W-1:0]    cmd_row,
  output logic [NB-1:0]       act_ok,
  output logic [NB-1:0]       rd_ok,
  output logic [NB-1:0]       wr_ok,
  output logic [NB-1:0]       pre_ok,
  output logic [NB-1:0]       bank_open,
  output logic [NB*ROW_W-1:0] open_row,
  output logic [NB-1:0]       close_req,
  output logic                col_err
);
  import dbt_pkg::*;

  localparam int T_WREC = T_WL + T_BURST + T_WR;
  localparam int T_W2R  = T_WL + T_BURST + T_WTR;

  logic             is_col, is_wr, sel_open, row_hit, col_acc;
  logic [ROW_W-1:0] sel_row;
  logic [NB-1:0]    col_ready;
  logic             rd_bus_ok, wr_bus_ok;

  assign is_col   = cmd_valid && (cmd_kind == CMD_RD || cmd_kind == CMD_WR);
  assign is_wr    = cmd_valid && cmd_kind == CMD_WR;
  assign sel_open = bank_open[cmd_bank];
  assign sel_row  = open_row[cmd_bank*ROW_W +: ROW_W];
  assign row_hit  = sel_open && sel_row == cmd_row;
  assign col_acc  = is_col && row_hit;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit_b;
    assign hit_b = cmd_bank == BANK_W'(b);

    dbt_bank #(
      .ROW_W(ROW_W), .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RAS(T_RAS),
      .T_RP(T_RP), .T_WREC(T_WREC), .MAX_ACC(MAX_ACC)
    ) u_bank (
      .clk      (clk),
      .rst      (rst),
      .act_fire (cmd_valid && cmd_kind == CMD_ACT && hit_b && !bank_open[b]),
      .col_fire (col_acc && hit_b),
      .wr_fire  (col_acc && is_wr && hit_b),
      .pre_fire (cmd_valid && cmd_kind == CMD_PRE && hit_b && bank_open[b]),
      .row_in   (cmd_row),
      .is_open  (bank_open[b]),
      .row_q    (open_row[b*ROW_W +: ROW_W]),
      .col_ready(col_ready[b]),
      .pre_ready(pre_ok[b]),
      .act_ready(act_ok[b]),
      .at_cap   (close_req[b])
    );
  end

  dbt_turn #(.CNT_W(CNT_W), .T_W2R(T_W2R), .T_RTW(T_RTW)) u_turn (
    .clk      (clk),
    .rst      (rst),
    .rd_fire  (col_acc && !is_wr),
    .wr_fire  (col_acc && is_wr),
    .rd_bus_ok(rd_bus_ok),
    .wr_bus_ok(wr_bus_ok)
  );

  assign rd_ok = col_ready & {NB{rd_bus_ok}};
  assign wr_ok = col_ready & {NB{wr_bus_ok}};

  always_ff @(posedge clk) begin
    if (rst) col_err <= 1'b0;
    else     col_err <= is_col && !row_hit;
  end
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NB      = 4,
  parameter int ROW_W   = 8,
  parameter int T_RCD   = 3,
  parameter int T_RP    = 3,
  parameter int T_WL    = 2,
  parameter int T_BURST = 2,
  parameter int T_WTR   = 2,
  parameter int BANK_W  = 2
) (
  input logic                clk,
  input logic                rst,
  input logic                cmd_valid,
  input logic [1:0]          cmd_kind,
  input logic [BANK_W-1:0]   cmd_bank,
  input logic [ROW_W-1:0]    cmd_row,
  input logic [NB-1:0]       act_ok,
  input logic [NB-1:0]       rd_ok,
  input logic [NB-1:0]       wr_ok,
  input logic [NB-1:0]       pre_ok,
  input logic [NB-1:0]       bank_open,
  input logic [NB*ROW_W-1:0] open_row,
  input logic [NB-1:0]       close_req,
  input logic                col_err
);
  logic acc_hit;
  assign acc_hit = bank_open[cmd_bank] && open_row[cmd_bank*ROW_W +: ROW_W] == cmd_row;

  p_act_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_kind == 2'd0 && !bank_open[cmd_bank])
    |=> (bank_open[$past(cmd_bank)] && open_row[$past(cmd_bank)*ROW_W +: ROW_W] == $past(cmd_row)));

  p_act_blocks_col_r2: assert property (@(posedge clk) disable iff (rst)
    (T_RCD > 1 && cmd_valid && cmd_kind == 2'd0 && !bank_open[cmd_bank])
    |=> !rd_ok[$past(cmd_bank)] && !wr_ok[$past(cmd_bank)]);

  p_pre_closes_r5: assert property (@(posedge clk) disable iff (rst)
    (T_RP > 1 && cmd_valid && cmd_kind == 2'd3 && bank_open[cmd_bank])
    |=> !bank_open[$past(cmd_bank)] && !act_ok[$past(cmd_bank)]);

  p_wr_blocks_rd_r6: assert property (@(posedge clk) disable iff (rst)
    (T_WL + T_BURST + T_WTR > 1 && cmd_valid && cmd_kind == 2'd2 && acc_hit)
    |=> rd_ok == '0);

  p_bad_col_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_kind == 2'd1 || cmd_kind == 2'd2) && !acc_hit) |=> col_err);

  p_err_needs_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    (!cmd_valid) |=> !col_err);

  p_cap_only_open_r8: assert property (@(posedge clk) disable iff (rst)
    (close_req & ~bank_open) == '0);
endmodule

bind dram_bank_tracker dbt_checker #(
  .NB(NB), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_WL(T_WL),
  .T_BURST(T_BURST), .T_WTR(T_WTR), .BANK_W(BANK_W)
) u_chk (.*);

// File: tb/tb_dram_bank_tracker.sv
`timescale 1ns/1ps
module tb_dram_bank_tracker;
  localparam int NB = 4, ROW_W = 8, BANK_W = 2;
  localparam int T_RCD = 3, T_RAS = 7, T_RP = 3, T_WR = 3, T_WL = 2;
  localparam int T_BURST = 2, T_WTR = 2, T_RTW = 2, MAX_ACC = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_kind = '0;
  logic [BANK_W-1:0] cmd_bank = '0;
  logic [ROW_W-1:0] cmd_row = '0;
  logic [NB-1:0] act_ok, rd_ok, wr_ok, pre_ok, bank_open, close_req;
  logic [NB*ROW_W-1:0] open_row;
  logic col_err;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dram_bank_tracker #(
    .NB(NB), .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP),
    .T_WR(T_WR), .T_WL(T_WL), .T_BURST(T_BURST), .T_WTR(T_WTR),
    .T_RTW(T_RTW), .MAX_ACC(MAX_ACC)
  ) dut (.*);

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // presents one command; returns at the falling edge after it was sampled
  task automatic issue(int kind, int bank, int row);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_bank = BANK_W'(bank); cmd_row = ROW_W'(row);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // index of the first falling edge (0 = right after issue) where flag is set
  task automatic first_high(input int which, input int bank, output int idx);
    idx = -1;
    for (int k = 0; k < 40; k++) begin
      logic f;
      case (which)
        0: f = act_ok[bank];
        1: f = rd_ok[bank];
        2: f = wr_ok[bank];
        default: f = pre_ok[bank];
      endcase
      if (f && idx < 0) idx = k;
      if (idx >= 0) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 act_ok", int'(act_ok), 15);
    check("R1 rd_ok", int'(rd_ok), 0);
    check("R1 wr_ok", int'(wr_ok), 0);
    check("R1 pre_ok", int'(pre_ok), 0);
    check("R1 open", int'(bank_open), 0);
    check("R1 close_req", int'(close_req), 0);
    check("R1 col_err", int'(col_err), 0);
  endtask

  task automatic t_activate();
    int i;
    issue(0, 0, 5);
    check("R2 open", int'(bank_open[0]), 1);
    check("R2 row", int'(open_row[7:0]), 5);
    check("R2 act blocked", int'(act_ok[0]), 0);
    first_high(1, 0, i);
    check("R2 rcd window", i, T_RCD - 1);
    issue(0, 1, 0);
    issue(3, 1, 0);
    repeat (4) @(negedge clk);
    issue(0, 0, 5);
    issue(3, 0, 5);
    repeat (4) @(negedge clk);
    issue(0, 0, 5);
    first_high(3, 0, i);
    check("R3 ras window", i, T_RAS - 1);
  endtask

  task automatic t_turnaround();
    int i;
    issue(1, 0, 5);
    check("R6 wr blocked after rd", int'(wr_ok[0]), 0);
    first_high(2, 0, i);
    check("R6 rtw window", i, T_RTW - 1);
    issue(2, 0, 5);
    first_high(1, 0, i);
    check("R6 wtr window", i, T_WL + T_BURST + T_WTR - 1);
    issue(2, 0, 5);
    first_high(3, 0, i);
    check("R4 write recovery", i, T_WL + T_BURST + T_WR - 1);
  endtask

  task automatic t_precharge();
    int i;
    issue(3, 0, 0);
    check("R5 closed", int'(bank_open[0]), 0);
    first_high(0, 0, i);
    check("R5 rp window", i, T_RP - 1);
  endtask

  task automatic t_bad_col();
    issue(1, 2, 4);
    check("R7 closed bank err", int'(col_err), 1);
    check("R7 stays closed", int'(bank_open[2]), 0);
    @(negedge clk);
    check("R7 err one cycle", int'(col_err), 0);
    issue(0, 1, 9);
    repeat (8) @(negedge clk);
    issue(1, 1, 3);
    check("R7 row mismatch err", int'(col_err), 1);
    check("R7 no turnaround load", int'(wr_ok[1]), 1);
    check("R7 row kept", int'(open_row[15:8]), 9);
  endtask

  task automatic t_cap();
    issue(0, 2, 7);
    repeat (4) @(negedge clk);
    for (int n = 0; n < MAX_ACC - 1; n++) issue(1, 2, 7);
    check("R8 below cap", int'(close_req[2]), 0);
    issue(1, 2, 7);
    check("R8 at cap", int'(close_req[2]), 1);
    issue(1, 2, 7);
    check("R8 stays", int'(close_req[2]), 1);
    repeat (8) @(negedge clk);
    issue(3, 2, 0);
    check("R8 cleared by pre", int'(close_req[2]), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_activate();
    t_turnaround();
    t_precharge();
    t_bad_col();
    t_cap();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule